// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Decoder

This block is the host-side front end of a two-channel UART. An 8-bit asynchronous processor bus reaches it through an active-low chip select, a channel select line, three address lines, active-low read and write strobes, and a data bus. The data bus is split into an input byte, an output byte and an output enable. The decoder synchronises these inputs to the system clock and finds the strobe edges. It then sends each access to one of two per-channel register stores. Each store is a simple 8-entry array that stands in for a channel's register file.

A shared option register sits at one address in both channel maps. Its lowest bit turns on concurrent write mode, in which a single write updates the same register in both channels. Reads keep following the channel select line in this mode. Two further bit pairs in the same register choose what drives each channel's multi-function output pin: the general-purpose output, the baud clock, or the receive-ready indicator.

Top module: `duart_hostbus`

## Requirements
- R1: While reset is high and after it is released, the output enable is low, the output byte is 0, every channel register reads 0, the option register reads 0 and both multi-function outputs follow their general-purpose source.
- R2: A write (chip select low, write strobe pulsed low then high) with channel select high stores the byte in channel A at the given address. With channel select low it stores it in channel B. The other channel is left unchanged.
- R3: Strobes applied while chip select is high change no register and never raise the output enable.
- R4: The output enable rises no sooner than three clock edges after chip select and the read strobe are both low, and it is low again three edges after the read strobe rises. While it is high, the output byte holds the addressed register of the selected channel.
- R5: Address 2 of either channel holds the shared option register. A write there updates only that register, and a read there from either channel returns it.
- R6: With option bit 0 set, a write to any address other than 2 updates that register in both channels.
- R7: With option bit 0 set, a read still returns the register of the channel chosen by channel select.
- R8: Option bits [2:1] choose channel A's multi-function source and bits [4:3] choose channel B's: 00 general-purpose output, 01 baud clock, 10 receive-ready, 11 general-purpose output.
- R9: A write stores the data byte present when the write strobe rises, not the byte present when it fell.
- R10: The output enable stays low for the whole of a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| csN | input | 1 | Chip select, active low |
| chSel | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| addr | input | 3 | Register address within the channel |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Byte driven by the host during writes |
| dataOut | output | 8 | Byte returned to the host during reads |
| dataOe | output | 1 | Data bus drive enable |
| op2A | input | 1 | Channel A general-purpose output source |
| baudA | input | 1 | Channel A baud clock source |
| rxRdyA | input | 1 | Channel A receive-ready source |
| op2B | input | 1 | Channel B general-purpose output source |
| baudB | input | 1 | Channel B baud clock source |
| rxRdyB | input | 1 | Channel B receive-ready source |
| mfoA | output | 1 | Channel A multi-function output |
| mfoB | output | 1 | Channel B multi-function output |

## Verification
A wrong steering decision leaves a byte in the wrong channel. It shows up on the very next read of that address from either channel, about a dozen clocks after the write. A corrupted option register shows at once on the multi-function outputs when the three sources differ, and as double or missing writes in the next access. Output-enable timing faults show within three edges of a read strobe edge, so the bench samples both inside and after each strobe.

// File: rtl/duart_pkg.sv
package duart_pkg;
  parameter int unsigned BUS_W  = 8;
  parameter int unsigned ADDR_W = 3;

  // per-access command from the control unit to the datapath
  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrOpt;
    logic              rdLoad;
    logic              rdChA;
    logic              rdOpt;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  data;
  } busStrobe_t;

  typedef enum logic [1:0] {
    MFO_OP2   = 2'b00,
    MFO_BAUD  = 2'b01,
    MFO_RXRDY = 2'b10,
    MFO_SPARE = 2'b11
  } mfoSel_e;
endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OPT_ADDR    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              chSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic              broadcast,
  output busStrobe_t        strb,
  output logic              dataOe
);
  localparam int unsigned SW = 4 + ADDR_W + BUS_W;
  localparam logic [SW-1:0] SYNC_IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}, {BUS_W{1'b0}}};

  logic [SYNC_STAGES-1:0][SW-1:0] syncQ;
  logic [SW-1:0] rawIn, syncOut;
  logic csS, chS, rdS, wrS, wrPrev, wrRise, hitOpt;
  logic [ADDR_W-1:0] addrS;
  logic [BUS_W-1:0]  dataS;

  assign rawIn = {csN, chSel, rdN, wrN, addr, dataIn};

  // shift-register synchronizer, all bus inputs in one bundle
  always_ff @(posedge clk) begin
    if (rst) syncQ <= {SYNC_STAGES{SYNC_IDLE}};
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign {csS, chS, rdS, wrS, addrS, dataS} = syncOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev <= 1'b1;
      dataOe <= 1'b0;
    end else begin
      wrPrev <= wrS;
      dataOe <= ~csS & ~rdS;
    end
  end

  assign wrRise = wrS & ~wrPrev & ~csS;
  assign hitOpt = (addrS == ADDR_W'(OPT_ADDR));

  always_comb begin
    strb.wrOpt  = wrRise & hitOpt;
    strb.wrA    = wrRise & ~hitOpt & (chS | broadcast);
    strb.wrB    = wrRise & ~hitOpt & (~chS | broadcast);
    strb.rdLoad = ~csS & ~rdS;
    strb.rdChA  = chS;
    strb.rdOpt  = hitOpt;
    strb.addr   = addrS;
    strb.data   = dataS;
  end
endmodule

// File: rtl/duart_dpath.sv
module duart_dpath
  import duart_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  busStrobe_t       strb,
  input  logic [N_CH-1:0]  op2,
  input  logic [N_CH-1:0]  baud,
  input  logic [N_CH-1:0]  rxRdy,
  output logic [BUS_W-1:0] dataOut,
  output logic             broadcast,
  output logic [N_CH-1:0]  mfo
);
  localparam int unsigned NUM_REGS = 2 ** ADDR_W;

  logic [BUS_W-1:0] optReg;
  logic [N_CH-1:0]  wrEn;
  logic [N_CH-1:0][BUS_W-1:0] chanRd;
  logic [BUS_W-1:0] rdByte;

  assign wrEn = {strb.wrB, strb.wrA};

  always_ff @(posedge clk) begin
    if (rst)             optReg <= '0;
    else if (strb.wrOpt) optReg <= strb.data;
  end
  assign broadcast = optReg[0];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [BUS_W-1:0] store [NUM_REGS];
    mfoSel_e sel;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NUM_REGS; i++) store[i] <= '0;
      end else if (wrEn[ch]) begin
        store[strb.addr] <= strb.data;
      end
    end
    assign chanRd[ch] = store[strb.addr];

    assign sel = mfoSel_e'(optReg[2*ch+2 -: 2]);
    always_comb begin
      unique case (sel)
        MFO_BAUD:  mfo[ch] = baud[ch];
        MFO_RXRDY: mfo[ch] = rxRdy[ch];
        default:   mfo[ch] = op2[ch];
      endcase
    end
  end

  always_comb begin
    if (strb.rdOpt)      rdByte = optReg;
    else if (strb.rdChA) rdByte = chanRd[0];
    else                 rdByte = chanRd[1];
  end

  always_ff @(posedge clk) begin
    if (rst)              dataOut <= '0;
    else if (strb.rdLoad) dataOut <= rdByte;
  end
endmodule

// File: rtl/duart_hostbus.sv
module duart_hostbus
  import duart_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OPT_ADDR    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              chSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [BUS_W-1:0]  dataOut,
  output logic              dataOe,
  input  logic              op2A,
  input  logic              baudA,
  input  logic              rxRdyA,
  input  logic              op2B,
  input  logic              baudB,
  input  logic              rxRdyB,
  output logic              mfoA,
  output logic              mfoB
);
  localparam int unsigned N_CH = 2;

  busStrobe_t      strb;
  logic            broadcast;
  logic [N_CH-1:0] mfoVec;

  duart_ctrl #(.SYNC_STAGES(SYNC_STAGES), .OPT_ADDR(OPT_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .chSel(chSel), .addr(addr),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .broadcast(broadcast),
    .strb(strb), .dataOe(dataOe)
  );

  duart_dpath #(.N_CH(N_CH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .op2({op2B, op2A}), .baud({baudB, baudA}), .rxRdy({rxRdyB, rxRdyA}),
    .dataOut(dataOut), .broadcast(broadcast), .mfo(mfoVec)
  );

  assign mfoA = mfoVec[0];
  assign mfoB = mfoVec[1];
endmodule

// File: rtl/duart_hostbus_chk.sv
module duart_hostbus_chk
  import duart_pkg::*;
#(
  parameter int unsigned OPT_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  dataOut,
  input logic              dataOe,
  input logic              op2A,
  input logic              baudA,
  input logic              rxRdyA,
  input logic              op2B,
  input logic              baudB,
  input logic              rxRdyB,
  input logic              mfoA,
  input logic              mfoB,
  input logic [BUS_W-1:0]  opt
);
  logic rstD;
  always_ff @(posedge clk) rstD <= rst;

  // R1
  always @(negedge clk) begin
    if (rstD) reset_idle_chk: assert (!dataOe && dataOut == '0);
  end

  // R4
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rdN, 3) |-> !dataOe);

  // R3
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $past(csN, 3) |-> !dataOe);

  // R5
  opt_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(opt) |-> ($past(wrN, 3) && !$past(wrN, 4) && !$past(csN, 3)
                       && $past(addr, 3) == ADDR_W'(OPT_ADDR)));

  // R8
  mfo_a_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (op2A == baudA && baudA == rxRdyA) |-> mfoA == op2A);

  // R8
  mfo_b_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (op2B == baudB && baudB == rxRdyB) |-> mfoB == op2B);
endmodule

bind duart_hostbus duart_hostbus_chk #(.OPT_ADDR(OPT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
  .dataOut(dataOut), .dataOe(dataOe),
  .op2A(op2A), .baudA(baudA), .rxRdyA(rxRdyA),
  .op2B(op2B), .baudB(baudB), .rxRdyB(rxRdyB),
  .mfoA(mfoA), .mfoB(mfoB), .opt(u_dp.optReg)
);

// File: tb/sim_duart_hostbus.sv
module sim_duart_hostbus;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, chSel = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;
  logic op2A = 1'b1, baudA = 1'b0, rxRdyA = 1'b0;
  logic op2B = 1'b1, baudB = 1'b0, rxRdyB = 1'b0;
  logic mfoA, mfoB;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  duart_hostbus u0 (
    .clk(clk), .rst(rst), .csN(csN), .chSel(chSel), .addr(addr),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .op2A(op2A), .baudA(baudA), .rxRdyA(rxRdyA),
    .op2B(op2B), .baudB(baudB), .rxRdyB(rxRdyB),
    .mfoA(mfoA), .mfoB(mfoB)
  );

  typedef struct packed {
    logic       isWr;
    logic       chA;
    logic [2:0] a;
    logic [7:0] d;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 3'd0, 8'h11},
    '{1'b1, 1'b0, 3'd0, 8'h22},
    '{1'b0, 1'b1, 3'd0, 8'h11},
    '{1'b0, 1'b0, 3'd0, 8'h22},
    '{1'b1, 1'b1, 3'd7, 8'hA5},
    '{1'b0, 1'b1, 3'd7, 8'hA5},
    '{1'b0, 1'b0, 3'd7, 8'h00},
    '{1'b1, 1'b0, 3'd5, 8'h3C},
    '{1'b0, 1'b0, 3'd5, 8'h3C},
    '{1'b0, 1'b1, 3'd5, 8'h00}
  };

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic wrOeSeen;

  task automatic busWrite(input logic chA, input logic [2:0] a, input logic [7:0] d,
                          input logic selLow);
    csN = ~selLow; chSel = chA; addr = a; dataIn = d;
    waitN(1);
    wrN = 1'b0;
    waitN(3);
    wrOeSeen = dataOe;
    waitN(1);
    wrN = 1'b1;
    waitN(4);
    csN = 1'b1;
    waitN(2);
  endtask

  task automatic busRead(input logic chA, input logic [2:0] a, input logic selLow,
                         output logic [7:0] got, output logic oeGot);
    csN = ~selLow; chSel = chA; addr = a;
    waitN(1);
    rdN = 1'b0;
    waitN(5);
    got = dataOut; oeGot = dataOe;
    rdN = 1'b1;
    waitN(5);
    csN = 1'b1;
    waitN(2);
  endtask

  task automatic readCheck(input string req, input logic chA, input logic [2:0] a,
                           input logic [7:0] exp);
    logic [7:0] got;
    logic oeGot;
    busRead(chA, a, 1'b1, got, oeGot);
    check(req, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic oeGot;
    waitN(5);
    // R1: state during reset
    check("R1 oe in reset", {7'b0, dataOe}, 8'h00);
    check("R1 dataOut in reset", dataOut, 8'h00);
    rst = 1'b0;
    waitN(3);
    check("R1 mfoA op2", {7'b0, mfoA}, {7'b0, op2A});
    check("R1 mfoB op2", {7'b0, mfoB}, {7'b0, op2B});
    readCheck("R1 chanA reg1", 1'b1, 3'd1, 8'h00);
    readCheck("R1 option reg", 1'b0, 3'd2, 8'h00);

    // R2 table of writes and reads
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) busWrite(VEC[i].chA, VEC[i].a, VEC[i].d, 1'b1);
      else readCheck("R2 table", VEC[i].chA, VEC[i].a, VEC[i].d);
    end

    // R10: oe low during write
    busWrite(1'b1, 3'd6, 8'h66, 1'b1);
    check("R10 oe during write", {7'b0, wrOeSeen}, 8'h00);

    // R3: chip select high
    busWrite(1'b1, 3'd1, 8'hFF, 1'b0);
    readCheck("R3 write ignored", 1'b1, 3'd1, 8'h00);
    busRead(1'b1, 3'd6, 1'b0, got, oeGot);
    check("R3 oe with cs high", {7'b0, oeGot}, 8'h00);

    // R4: oe timing and data
    csN = 1'b0; chSel = 1'b1; addr = 3'd6;
    waitN(1);
    rdN = 1'b0;
    waitN(1);
    check("R4 oe not early", {7'b0, dataOe}, 8'h00);
    waitN(3);
    check("R4 oe asserted", {7'b0, dataOe}, 8'h01);
    check("R4 read data", dataOut, 8'h66);
    rdN = 1'b1;
    waitN(1);
    check("R4 oe held", {7'b0, dataOe}, 8'h01);
    waitN(3);
    check("R4 oe released", {7'b0, dataOe}, 8'h00);
    csN = 1'b1;
    waitN(2);

    // R5: option register shared
    busWrite(1'b0, 3'd2, 8'h18, 1'b1);
    readCheck("R5 option via A", 1'b1, 3'd2, 8'h18);
    readCheck("R5 option via B", 1'b0, 3'd2, 8'h18);

    // R8: multi-function selection
    busWrite(1'b1, 3'd2, 8'h12, 1'b1); // A=baud, B=rxRdy
    op2A = 1'b0; baudA = 1'b1; rxRdyA = 1'b0;
    op2B = 1'b0; baudB = 1'b0; rxRdyB = 1'b1;
    waitN(1);
    check("R8 A baud high", {7'b0, mfoA}, 8'h01);
    check("R8 B rxRdy high", {7'b0, mfoB}, 8'h01);
    baudA = 1'b0; rxRdyA = 1'b1;
    waitN(1);
    check("R8 A baud low", {7'b0, mfoA}, 8'h00);
    busWrite(1'b1, 3'd2, 8'h1C, 1'b1); // A=rxRdy, B=code 11 -> op2
    check("R8 A rxRdy", {7'b0, mfoA}, 8'h01);
    check("R8 B code 11 op2", {7'b0, mfoB}, 8'h00);
    op2B = 1'b1;
    waitN(1);
    check("R8 B code 11 op2 high", {7'b0, mfoB}, 8'h01);

    // R7/R6: concurrent write mode
    busWrite(1'b1, 3'd3, 8'h44, 1'b1);
    busWrite(1'b0, 3'd3, 8'h55, 1'b1);
    busWrite(1'b1, 3'd2, 8'h01, 1'b1);
    check("R8 A op2 code 00", {7'b0, mfoA}, {7'b0, op2A});
    readCheck("R7 read A in broadcast", 1'b1, 3'd3, 8'h44);
    readCheck("R7 read B in broadcast", 1'b0, 3'd3, 8'h55);
    busWrite(1'b1, 3'd4, 8'h99, 1'b1);
    readCheck("R6 broadcast A", 1'b1, 3'd4, 8'h99);
    readCheck("R6 broadcast B", 1'b0, 3'd4, 8'h99);
    busWrite(1'b0, 3'd2, 8'h00, 1'b1);
    busWrite(1'b1, 3'd4, 8'h01, 1'b1);
    readCheck("R6 broadcast off A", 1'b1, 3'd4, 8'h01);
    readCheck("R6 broadcast off B", 1'b0, 3'd4, 8'h99);

    // R9: data sampled at strobe rise
    csN = 1'b0; chSel = 1'b0; addr = 3'd1; dataIn = 8'hAA;
    waitN(1);
    wrN = 1'b0;
    waitN(3);
    dataIn = 8'h5B;
    waitN(3);
    wrN = 1'b1;
    waitN(4);
    csN = 1'b1;
    waitN(2);
    readCheck("R9 late data", 1'b0, 3'd1, 8'h5B);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule